// File: doc/BRIEF.md
# External Sync Macrocycle Timer

This block marks macrocycle boundaries for a fieldbus master. A free-running period counter reloads every `mcyc_len` clock cycles and raises a one-cycle start strobe at each boundary. An external synchronisation pulse can also force a boundary. The pulse input is resynchronised to the clock inside the block, and only its rising edges count as pulse events.

Whether a pulse event restarts the macrocycle depends on three control inputs. The first is an active-low gate. The second is a mode bit: either every event restarts, or only events that arrive while the processor holds the safe-window input high. Events that are refused for timing still advance the pulse counter. Software can therefore compare the pulse count with the macrocycle count and detect a sync source that runs at the wrong rate, while the macrocycle keeps its own steady period.

Two wrapping counters are exposed: one for external pulse events and one for macrocycle starts. The asynchronous `rst_n` models application start. The synchronous `core_rst` clears the period counter and both counters. The pulse counter also has its own clear input.

Top module: `mcyc_sync_timer`

## Requirements
- R1: While `rst_n` is low, and on the clock edge after `core_rst` is sampled high, `pulse_cnt` and `mcyc_cnt` are 0 and `mcyc_start` is 0. The period counter restarts from zero.
- R2: `ext_pulse_i` passes through a two-stage synchroniser and a rising-edge detector. A rising edge first sampled at clock edge k takes effect on the outputs at edge k+2. A level that stays high produces only one event.
- R3: With no accepted pulse, `mcyc_start` is high for one cycle every `mcyc_len` cycles. The first strobe after a reset comes `mcyc_len` cycles after the reset is released. A length of 0 or 1 gives a strobe on every cycle.
- R4: With `ext_oe_n` = 1, pulse events never cause a strobe and never shift the internal period.
- R5: With `ext_oe_n` = 0 and `win_mode` = 0, every pulse event produces a strobe and restarts the period. The next internal strobe comes `mcyc_len` cycles later.
- R6: With `ext_oe_n` = 0 and `win_mode` = 1, a pulse event restarts the macrocycle only if `safe_win` = 1 in the cycle it is detected. Otherwise it is ignored for timing.
- R7: `pulse_cnt` increments by one on every pulse event, whatever the state of `ext_oe_n`, `win_mode` and `safe_win`.
- R8: `pcnt_clr` = 1 clears `pulse_cnt` on the next edge and takes priority over a pulse event detected in the same cycle. It does not change `mcyc_cnt` or the period.
- R9: `mcyc_cnt` increments by exactly one on each strobe. An accepted pulse event and an internal terminal count in the same cycle produce a single strobe and a single increment.
- R10: Both counters wrap from all-ones to zero and never saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low application-start reset |
| core_rst | input | 1 | Synchronous core reset, active high |
| ext_pulse_i | input | 1 | Asynchronous external sync pulse |
| ext_oe_n | input | 1 | 0: pulses may restart the macrocycle; 1: internal timing only |
| win_mode | input | 1 | 0: every pulse restarts; 1: restart only inside the safe window |
| safe_win | input | 1 | Processor flag: 1 when a new pulse is safe to accept |
| pcnt_clr | input | 1 | Clears the pulse counter |
| mcyc_len | input | LEN_W | Macrocycle length in clock cycles |
| pulse_cnt | output | CNT_W | Count of external pulse events |
| mcyc_cnt | output | CNT_W | Count of macrocycle starts |
| mcyc_start | output | 1 | One-cycle macrocycle start strobe |

## Verification
The bench builds the block with `CNT_W` = 4 and `LEN_W` = 8. The narrow counters wrap after 16 events, so twenty short macrocycles and a burst of pulses reach the R10 roll-over in a few hundred cycles instead of years. Macrocycle lengths of 10 and 20 cycles let a pulse every 10 cycles exercise the windowed mode: every second pulse is refused, and accepted pulses land on the same cycle as the internal terminal count. Lengths of 4 and 1 cover the shortest periods.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   // Gating controls that decide whether a pulse event may restart timing
   typedef struct packed {
      logic oe_n;   // 1: external pulses are ignored for timing
      logic win;    // 1: accept only inside the safe window
      logic safe;   // safe window currently open
   } gate_cfg_t;

   function automatic logic pulse_accepted(input gate_cfg_t cfg, input logic evt);
      return evt & ~cfg.oe_n & (~cfg.win | cfg.safe);
   endfunction

endpackage

// File: rtl/mcyc_edge_sync.sv
module mcyc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   localparam int TOP = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mcyc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] sh_q;
   logic         prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[TOP-1:0], din};
         prev_q <= sh_q[TOP];
      end
   end

   assign rise = sh_q[TOP] & ~prev_q;

   // R2: an edge event lasts exactly one cycle
   p_single_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/mcyc_wrap_cnt.sv
module mcyc_wrap_cnt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   generate
      if (W < 2) begin : g_bad_width
         $error("mcyc_wrap_cnt: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clr)    q <= '0;
      else if (inc)    q <= q + 1'b1;
   end

   p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));

   p_step_wraps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> (q == W'($past(q) + 1'b1)));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(q));

endmodule

// File: rtl/mcyc_period.sv
module mcyc_period
   import mcyc_pkg::*;
#(
   parameter int LEN_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_rst,
   input  logic [LEN_W-1:0] len,
   input  logic             ext_evt,
   input  gate_cfg_t        cfg,
   output logic             start_evt,
   output logic             start_q
);
   localparam int EXT_W = LEN_W + 1;

   generate
      if (LEN_W < 2) begin : g_bad_len
         $error("mcyc_period: LEN_W must be at least 2");
      end
   endgenerate

   logic [LEN_W-1:0] cnt_q;
   logic [EXT_W-1:0] cnt_next;
   logic             term;
   logic             accept;

   assign cnt_next  = {1'b0, cnt_q} + 1'b1;
   // terminal when cnt >= len-1; lengths 0 and 1 strobe every cycle
   assign term      = (cnt_next >= {1'b0, len});
   assign accept    = pulse_accepted(cfg, ext_evt);
   // a coincident accept and terminal count merge into one start
   assign start_evt = accept | term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         start_q <= 1'b0;
      end else if (core_rst) begin
         cnt_q   <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= start_evt;
         cnt_q   <= start_evt ? '0 : cnt_q + 1'b1;
      end
   end

   p_accept_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !core_rst) |=> (start_q && cnt_q == '0));

   p_gated_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_evt && cfg.oe_n && !term) |=> !start_q);

   p_outside_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_evt && cfg.win && !cfg.safe && !term) |=> !start_q);

endmodule

// File: rtl/mcyc_sync_timer.sv
module mcyc_sync_timer
   import mcyc_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int LEN_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_rst,
   input  logic             ext_pulse_i,
   input  logic             ext_oe_n,
   input  logic             win_mode,
   input  logic             safe_win,
   input  logic             pcnt_clr,
   input  logic [LEN_W-1:0] mcyc_len,
   output logic [CNT_W-1:0] pulse_cnt,
   output logic [CNT_W-1:0] mcyc_cnt,
   output logic             mcyc_start
);
   logic      pulse_evt;
   logic      start_evt;
   gate_cfg_t cfg;

   assign cfg = '{oe_n: ext_oe_n, win: win_mode, safe: safe_win};

   mcyc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (ext_pulse_i),
      .rise  (pulse_evt)
   );

   mcyc_period #(.LEN_W(LEN_W)) u_period (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_rst  (core_rst),
      .len       (mcyc_len),
      .ext_evt   (pulse_evt),
      .cfg       (cfg),
      .start_evt (start_evt),
      .start_q   (mcyc_start)
   );

   mcyc_wrap_cnt #(.W(CNT_W)) u_pulse_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (core_rst | pcnt_clr),
      .inc   (pulse_evt),
      .q     (pulse_cnt)
   );

   mcyc_wrap_cnt #(.W(CNT_W)) u_mcyc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (core_rst),
      .inc   (start_evt & ~core_rst),
      .q     (mcyc_cnt)
   );

   p_core_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> (pulse_cnt == '0 && mcyc_cnt == '0 && !mcyc_start));

   p_one_count_per_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mcyc_start && !$past(core_rst)) |-> (mcyc_cnt == CNT_W'($past(mcyc_cnt) + 1'b1)));

   p_pulse_clear_keeps_mcyc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt_clr && !core_rst && !start_evt) |=> $stable(mcyc_cnt));

endmodule

// File: tb/test_mcyc_sync_timer.sv
`timescale 1ns/1ps
module test_mcyc_sync_timer;
   localparam int CW = 4;
   localparam int LW = 8;
   localparam int MASK = (1 << CW) - 1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0, core_rst = 1'b0, ext_pulse = 1'b0;
   logic          oe_n = 1'b1, win = 1'b0, safe = 1'b0, pclr = 1'b0;
   logic [LW-1:0] len = 8'd10;
   logic [CW-1:0] pulse_cnt, mcyc_cnt;
   logic          mcyc_start;

   mcyc_sync_timer #(.CNT_W(CW), .LEN_W(LW), .SYNC_STAGES(2)) i_mcyc_sync_timer (
      .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .ext_pulse_i(ext_pulse),
      .ext_oe_n(oe_n), .win_mode(win), .safe_win(safe), .pcnt_clr(pclr),
      .mcyc_len(len), .pulse_cnt(pulse_cnt), .mcyc_cnt(mcyc_cnt),
      .mcyc_start(mcyc_start)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int q[$];
   int errors = 0, checks = 0;
   int exp_mcyc = 0, exp_pcnt = 0, next_int = 0, L = 10;
   bit model_on = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pops expected start cycles as strobes appear
   always @(negedge clk) begin : mon
      int e;
      if (rst_n && model_on) begin
         if (q.size() > 0 && q[0] < cyc) begin
            e = q.pop_front();
            chk(1'b0, "R3", "missing start strobe at cycle", cyc, e);
         end
         if (mcyc_start) begin
            if (q.size() == 0) chk(1'b0, "R4", "unexpected start at cycle", cyc, -1);
            else begin
               e = q.pop_front();
               chk(e == cyc, "R9", "start strobe cycle", cyc, e);
            end
         end
      end
   end

   // driver: one clock step; predicts the start 3 edges ahead
   task automatic tick(input bit raise, input bit clr);
      int  t;
      bit  ev;
      @(negedge clk);
      ext_pulse = raise;
      pclr      = clr;
      t  = cyc + 3;
      ev = raise && !oe_n && (!win || safe);
      if (raise) exp_pcnt++;
      if (clr) exp_pcnt = 0;
      if (ev || t == next_int) begin
         q.push_back(t);
         exp_mcyc++;
         next_int = t + L;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) tick(1'b0, 1'b0);
   endtask

   task automatic restart(input int new_len, input bit model);
      int c;
      @(negedge clk);
      c = cyc;
      ext_pulse = 1'b0; pclr = 1'b0;
      core_rst = 1'b1;
      len = LW'(new_len);
      L = new_len;
      q = q.find(x) with (x <= c);
      @(negedge clk);
      core_rst = 1'b0;
      exp_mcyc = 0; exp_pcnt = 0;
      next_int = cyc + L;
      model_on = model;
   endtask

   task automatic check_counts(input string req);
      int pend = 0;
      foreach (q[i]) if (q[i] > cyc) pend++;
      chk(int'(mcyc_cnt) == ((exp_mcyc - pend) & MASK), req, "mcyc_cnt",
          int'(mcyc_cnt), (exp_mcyc - pend) & MASK);
      chk(int'(pulse_cnt) == (exp_pcnt & MASK), req, "pulse_cnt",
          int'(pulse_cnt), exp_pcnt & MASK);
   endtask

   initial begin : watchdog
      #500000;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pulse_cnt == '0, "R1", "pulse_cnt in reset", int'(pulse_cnt), 0);
      chk(mcyc_cnt == '0, "R1", "mcyc_cnt in reset", int'(mcyc_cnt), 0);
      chk(mcyc_start == 1'b0, "R1", "strobe in reset", int'(mcyc_start), 0);
      @(negedge clk);
      rst_n = 1'b1;
      L = 10; next_int = cyc + L; model_on = 1'b1;

      // R3: free run, three periods
      idle(35);
      check_counts("R3");

      // R4 and R7: pulse with gate off is counted but ignored for timing
      tick(1'b1, 1'b0);
      idle(12);
      check_counts("R4");

      // R2 and R5: immediate mode, pulse restarts the period
      oe_n = 1'b0; win = 1'b0; safe = 1'b0;
      idle(3);
      tick(1'b1, 1'b0);
      idle(25);
      check_counts("R5");

      // R6: window mode, closed window rejects, open window accepts
      win = 1'b1; safe = 1'b0;
      tick(1'b1, 1'b0);
      idle(14);
      check_counts("R6");
      safe = 1'b1;
      tick(1'b1, 1'b0);
      idle(25);
      check_counts("R6");

      // R8: clear coincides with a pulse event; mcyc_cnt untouched
      oe_n = 1'b1;
      tick(1'b1, 1'b0);
      tick(1'b0, 1'b0);
      tick(1'b0, 1'b1);
      idle(3);
      chk(pulse_cnt == '0, "R8", "pulse_cnt after clear", int'(pulse_cnt), 0);
      check_counts("R8");

      // R1: core reset clears both counters
      restart(20, 1'b1);
      chk(pulse_cnt == '0 && mcyc_cnt == '0, "R1", "counters after core reset",
          int'(pulse_cnt) + int'(mcyc_cnt), 0);

      // R6, R7, R9: 20-cycle macrocycle, pulses every 10, every second refused
      oe_n = 1'b0; win = 1'b1;
      for (int k = 0; k < 8; k++) begin
         safe = (k % 2 == 0);
         tick(1'b1, 1'b0);
         idle(9);
      end
      idle(4);
      chk(int'(pulse_cnt) == 8, "R7", "pulses counted incl. refused", int'(pulse_cnt), 8);
      check_counts("R9");

      // R10: wrap of both counters with a 4-cycle period
      restart(4, 1'b1);
      oe_n = 1'b1;
      for (int k = 0; k < 18; k++) begin
         tick(1'b1, 1'b0);
         idle(3);
      end
      idle(8);
      chk(int'(pulse_cnt) == (18 & MASK), "R10", "pulse_cnt wrap", int'(pulse_cnt), 18 & MASK);
      check_counts("R10");

      // R3: length 1 strobes on every cycle
      restart(1, 1'b0);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         chk(mcyc_start == 1'b1, "R3", "strobe with length 1", int'(mcyc_start), 1);
         chk(int'(mcyc_cnt) == k, "R3", "mcyc_cnt with length 1", int'(mcyc_cnt), k);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule